// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block is the digital control engine of a successive-approximation converter front end. It holds a 32-bit mode register that is written over a simple one-register write port, and a write-protect input can lock that register. The peripheral clock is divided into a conversion clock. One of several hardware trigger inputs is selected, and its edges start a sequence. A sequence walks the enabled channels in ascending index order, or walks a programmed slot list.

Each conversion passes through an optional start-up wait, then tracking, conversion and transfer phases. Every phase length is counted in conversion-clock periods. The start-up length comes from a non-linear lookup and the tracking length from a piecewise formula. The converter itself is modelled as a fixed number of conversion-clock periods (`CONV_CLKS`). At the end of each transfer a one-cycle result strobe carries the channel index. Between sequences the core and reference power enables follow one of three power levels.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `reg_rdata` reads 32'h2000_0000, so the 2-bit transfer field in bits 29:28 holds 2. Only bits 31:23, 19:8, 6:5 and 3:1 are stored (mask 32'hFF8F_FF6E); every other bit reads 0.
- R2: A write (`reg_wr` high) loads `reg_wdata` masked into the mode register when `wp_en` is low. The write is ignored while `wp_en` is high.
- R3: The conversion clock period is 2 × (P + 1) clock cycles, where P is bits 15:8. The divider restarts on the accepting trigger edge, so a sequence's k-th period ends exactly k × 2 × (P + 1) cycles after that edge.
- R4: The start-up wait for code S in bits 19:16 is 0, 8, 16, 24, 64, 80, 96 or 112 periods for S = 0 to 7, and 512 + 64 × (S − 8) periods for S = 8 to 15. The wait is inserted only on the first conversion of a sequence, and only when `core_en` was low at the trigger. A wait of 0 skips the phase.
- R5: With `ext_track` low, the tracking length for code K in bits 27:24 is 6 periods for K = 0 to 14 and 7 periods for K = 15. With `ext_track` high it is 6 periods for K = 0 to 3 and 4 × (K + 1) − 10 periods for K = 4 to 15.
- R6: The conversion phase lasts `CONV_CLKS` periods. The transfer phase lasts X + 1 periods, where X is bits 29:28. `res_valid` is high for one cycle after the transfer ends, with `res_chan` set to the converted channel.
- R7: With bit 31 clear, a sequence converts every channel whose `chan_en` bit is set, in ascending index order, and then returns to idle.
- R8: With bit 31 set, a sequence converts `seq_list` slots 0 up to `seq_len` − 1 in slot order. Slot s is `seq_list[4s+3:4s]`. A channel may repeat, and `chan_en` is not used.
- R9: While a sequence runs, `core_en` and `ref_en` are high. In idle, with bit 5 (sleep) clear both are high. With sleep set and bit 6 (fast wake-up) clear both are low. With sleep and fast wake-up both set, only `ref_en` is high.
- R10: Trigger select code T in bits 3:1 picks `trig_in[T]` for T = 0 to 4. Codes 5 to 7 pick no input, so no sequence starts.
- R11: `trig_mode` 0 starts nothing. 1 starts on a rising edge of the selected input, 2 on a falling edge, and 3 on either edge.
- R12: `phase` (0 idle, 1 start-up, 2 track, 3 convert, 4 transfer) only moves idle→start-up or track, start-up→track, track→convert, convert→transfer, and transfer→track or idle. A trigger edge that arrives while a sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Mode register write strobe |
| reg_wdata | input | 32 | Mode register write data |
| wp_en | input | 1 | Write protect; blocks writes while high |
| reg_rdata | output | 32 | Mode register contents |
| trig_mode | input | 2 | Trigger edge mode (0 off, 1 rise, 2 fall, 3 both) |
| trig_in | input | NTRIG | Hardware trigger inputs |
| ext_track | input | 1 | Extended tracking-time flag |
| chan_en | input | NCH | Channel enables for numeric order |
| seq_list | input | SLOTS×4 | Programmed channel slots, slot 0 in the low bits |
| seq_len | input | clog2(SLOTS+1) | Number of slots used |
| conv_clk | output | 1 | Conversion clock, low while idle |
| core_en | output | 1 | Converter core power enable |
| ref_en | output | 1 | Reference power enable |
| phase | output | 3 | Current phase code |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | clog2(NCH) | Channel of the finished conversion |

## Verification
The bench builds the block with NCH = 16, SLOTS = 8, NTRIG = 5 and CONV_CLKS = 3. The short conversion phase keeps the full lookup values in reach, such as a 576-period start-up and a 54-period extended track, within a few thousand cycles. Sixteen channels let the ascending walk skip gaps and reach the top index 15. Five trigger inputs leave three select codes reserved, and those are exercised directly.

// File: rtl/adc_seq_pkg.sv
// Package adc_seq_pkg
// Shared phase encoding, mode-register layout and phase-length lookups
// for the conversion timing sequencer. Assumes a 32-bit mode register.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_TRACK = 3'd2,
        PH_CONV  = 3'd3,
        PH_XFER  = 3'd4
    } phase_t;

    localparam int          MR_W     = 32;
    localparam logic [31:0] MR_RESET = 32'h2000_0000;
    localparam logic [31:0] MR_MASK  = 32'hFF8F_FF6E;

    localparam int B_USEQ    = 31;
    localparam int B_XFER_LO = 28;
    localparam int B_TRK_LO  = 24;
    localparam int B_SU_LO   = 16;
    localparam int B_PRE_LO  = 8;
    localparam int B_FWUP    = 6;
    localparam int B_SLEEP   = 5;
    localparam int B_TSEL_LO = 1;

    localparam int LEN_W = 10;

    // Start-up periods: low codes grow in steps of 8 then 16, high codes in steps of 64.
    function automatic logic [LEN_W-1:0] startup_len(input logic [3:0] code);
        logic [LEN_W-1:0] r;
        if (code[3])
            r = LEN_W'(512) + LEN_W'({code[2:0], 6'b0});
        else if (code[2])
            r = LEN_W'(64) + LEN_W'({code[1:0], 4'b0});
        else
            r = LEN_W'({code[1:0], 3'b0});
        return r;
    endfunction

    // Tracking periods: piecewise on the extended flag and the code.
    function automatic logic [LEN_W-1:0] track_len(input logic [3:0] code, input logic ext);
        logic [LEN_W-1:0] r;
        if (ext && (code >= 4'd4))
            r = LEN_W'({code, 2'b00}) - LEN_W'(6);
        else if (!ext && (code == 4'd15))
            r = LEN_W'(7);
        else
            r = LEN_W'(6);
        return r;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
// Module adc_clk_div
// Divides the peripheral clock into a conversion clock of 2*(P+1) cycles.
// Held in reset while run is low, so the first period of a sequence is
// aligned to the cycle that starts it. Assumes P is stable while running.
module adc_clk_div #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] prescal,
    output logic          tick,
    output logic          conv_clk
);
    localparam int CW = PW + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] half;
    logic [CW-1:0] last;

    assign half     = {1'b0, prescal};
    assign last     = {prescal, 1'b1};
    assign tick     = run && (cnt == last);
    assign conv_clk = run && (cnt > half);

    // Period counter: wraps on tick, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/adc_trig_sel.sv
// Module adc_trig_sel
// Picks one hardware trigger input by code, and detects its edges per mode
// (0 off, 1 rising, 2 falling, 3 both). Codes at or above NTRIG select a
// constant low. Assumes inputs are already synchronous to clk.
module adc_trig_sel #(
    parameter int NTRIG = 5,
    parameter int SW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_in,
    input  logic [SW-1:0]    sel,
    input  logic [1:0]       mode,
    output logic             fire
);
    logic cur;
    logic prev;
    logic rise;
    logic fall;

    // Input multiplexer; reserved codes fall through to low.
    always_comb begin
        cur = 1'b0;
        for (int i = 0; i < NTRIG; i++)
            if (sel == SW'(i))
                cur = trig_in[i];
    end

    // Previous value of the selected input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev <= 1'b0;
        else
            prev <= cur;
    end

    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    // Edge qualification by trigger mode.
    always_comb begin
        case (mode)
            2'd1:    fire = rise;
            2'd2:    fire = fall;
            2'd3:    fire = rise | fall;
            default: fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_chan_pick.sv
// Module adc_chan_pick
// Finds the next channel from a cursor. Numeric mode: the lowest enabled
// index at or above the cursor. List mode: the slot at the cursor while it
// is below the list length. Assumes NCH >= SLOTS so one cursor width fits both.
module adc_chan_pick #(
    parameter int NCH   = 16,
    parameter int SLOTS = 8,
    parameter int CHW   = 4,
    parameter int CUW   = 5,
    parameter int LW    = 4
) (
    input  logic                 useq,
    input  logic [NCH-1:0]       chan_en,
    input  logic [SLOTS*CHW-1:0] seq_list,
    input  logic [LW-1:0]        seq_len,
    input  logic [CUW-1:0]       cursor,
    output logic                 found,
    output logic [CHW-1:0]       chan,
    output logic [CUW-1:0]       cursor_nxt
);
    // Next-channel search for both orderings.
    always_comb begin
        found      = 1'b0;
        chan       = '0;
        cursor_nxt = cursor;
        if (useq) begin
            found      = (cursor < CUW'(seq_len)) && (cursor < CUW'(SLOTS));
            cursor_nxt = cursor + CUW'(1);
            for (int s = 0; s < SLOTS; s++)
                if (cursor == CUW'(s))
                    chan = seq_list[s*CHW +: CHW];
        end else begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (chan_en[i] && (CUW'(i) >= cursor)) begin
                    found      = 1'b1;
                    chan       = CHW'(i);
                    cursor_nxt = CUW'(i + 1);
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Module adc_seq_ctrl
// Top of the conversion timing sequencer: mode register with write protect,
// conversion clock divider, trigger selection, channel walk and the
// per-conversion phase machine with power gating between sequences.
// Assumes mode fields are only changed while idle.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int SLOTS     = 8,
    parameter int NTRIG     = 5,
    parameter int CONV_CLKS = 12,
    localparam int CHW = $clog2(NCH),
    localparam int CUW = CHW + 1,
    localparam int LW  = $clog2(SLOTS + 1),
    localparam int SLW = SLOTS * CHW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [MR_W-1:0]  reg_wdata,
    input  logic             wp_en,
    output logic [MR_W-1:0]  reg_rdata,
    input  logic [1:0]       trig_mode,
    input  logic [NTRIG-1:0] trig_in,
    input  logic             ext_track,
    input  logic [NCH-1:0]   chan_en,
    input  logic [SLW-1:0]   seq_list,
    input  logic [LW-1:0]    seq_len,
    output logic             conv_clk,
    output logic             core_en,
    output logic             ref_en,
    output logic [2:0]       phase,
    output logic             res_valid,
    output logic [CHW-1:0]   res_chan
);
    logic [MR_W-1:0]  mode_q;
    phase_t           st;
    phase_t           st_nxt;
    logic [LEN_W-1:0] ph_cnt;
    logic [LEN_W-1:0] ph_len;
    logic [LEN_W-1:0] su_len;
    logic [LEN_W-1:0] tr_len;
    logic [CUW-1:0]   cursor;
    logic [CUW-1:0]   cursor_nxt;
    logic [CHW-1:0]   cur_ch;
    logic [CHW-1:0]   pick_ch;
    logic             found;
    logic             tick;
    logic             fire;
    logic             ph_done;
    logic             start_ok;
    logic             need_su;
    logic             advance;
    logic             core_q;
    logic             ref_q;

    logic             f_useq;
    logic [1:0]       f_xfer;
    logic [3:0]       f_trk;
    logic [3:0]       f_su;
    logic [7:0]       f_pre;
    logic             f_fwup;
    logic             f_sleep;
    logic [2:0]       f_tsel;

    assign f_useq  = mode_q[B_USEQ];
    assign f_xfer  = mode_q[B_XFER_LO +: 2];
    assign f_trk   = mode_q[B_TRK_LO +: 4];
    assign f_su    = mode_q[B_SU_LO +: 4];
    assign f_pre   = mode_q[B_PRE_LO +: 8];
    assign f_fwup  = mode_q[B_FWUP];
    assign f_sleep = mode_q[B_SLEEP];
    assign f_tsel  = mode_q[B_TSEL_LO +: 3];

    // Mode register: masked load unless write protect is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MR_RESET;
        else if (reg_wr && !wp_en)
            mode_q <= reg_wdata & MR_MASK;
    end

    assign reg_rdata = mode_q;

    adc_clk_div #(.PW(8)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st != PH_IDLE),
        .prescal  (f_pre),
        .tick     (tick),
        .conv_clk (conv_clk)
    );

    adc_trig_sel #(.NTRIG(NTRIG), .SW(3)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .sel     (f_tsel),
        .mode    (trig_mode),
        .fire    (fire)
    );

    adc_chan_pick #(
        .NCH(NCH), .SLOTS(SLOTS), .CHW(CHW), .CUW(CUW), .LW(LW)
    ) u_pick (
        .useq       (f_useq),
        .chan_en    (chan_en),
        .seq_list   (seq_list),
        .seq_len    (seq_len),
        .cursor     (cursor),
        .found      (found),
        .chan       (pick_ch),
        .cursor_nxt (cursor_nxt)
    );

    assign su_len = startup_len(f_su);
    assign tr_len = track_len(f_trk, ext_track);

    // Length of the phase currently running, in conversion-clock periods.
    always_comb begin
        case (st)
            PH_START: ph_len = su_len;
            PH_TRACK: ph_len = tr_len;
            PH_CONV:  ph_len = LEN_W'(CONV_CLKS);
            PH_XFER:  ph_len = LEN_W'(f_xfer) + LEN_W'(1);
            default:  ph_len = LEN_W'(1);
        endcase
    end

    assign ph_done  = tick && (ph_cnt == ph_len - LEN_W'(1));
    assign start_ok = (st == PH_IDLE) && fire && found;
    assign need_su  = !core_q && (su_len != '0);
    assign advance  = start_ok || ((st == PH_XFER) && ph_done && found);

    // Phase sequencing; triggers are only looked at in idle.
    always_comb begin
        st_nxt = st;
        case (st)
            PH_IDLE:  if (start_ok) st_nxt = need_su ? PH_START : PH_TRACK;
            PH_START: if (ph_done)  st_nxt = PH_TRACK;
            PH_TRACK: if (ph_done)  st_nxt = PH_CONV;
            PH_CONV:  if (ph_done)  st_nxt = PH_XFER;
            PH_XFER:  if (ph_done)  st_nxt = found ? PH_TRACK : PH_IDLE;
            default:  st_nxt = PH_IDLE;
        endcase
    end

    // Phase register and period counter within the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PH_IDLE;
            ph_cnt <= '0;
        end else begin
            st <= st_nxt;
            if (st_nxt != st)
                ph_cnt <= '0;
            else if (tick)
                ph_cnt <= ph_cnt + LEN_W'(1);
        end
    end

    // Channel cursor and current channel; cursor rewinds in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor <= '0;
            cur_ch <= '0;
        end else if (advance) begin
            cursor <= cursor_nxt;
            cur_ch <= pick_ch;
        end else if (st_nxt == PH_IDLE) begin
            cursor <= '0;
        end
    end

    // Result strobe at the end of each transfer phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_chan  <= '0;
        end else begin
            res_valid <= (st == PH_XFER) && ph_done;
            if ((st == PH_XFER) && ph_done)
                res_chan <= cur_ch;
        end
    end

    // Power enables: full on in a sequence, sleep level in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= 1'b0;
            ref_q  <= 1'b0;
        end else if (st_nxt != PH_IDLE) begin
            core_q <= 1'b1;
            ref_q  <= 1'b1;
        end else begin
            core_q <= ~f_sleep;
            ref_q  <= ~f_sleep | f_fwup;
        end
    end

    assign core_en = core_q;
    assign ref_en  = ref_q;
    assign phase   = st;
endmodule

// File: rtl/adc_seq_chk.sv
// Module adc_seq_chk
// Port-level properties of the conversion timing sequencer, bound into
// every instance of adc_seq_ctrl. Phase codes: 0 idle, 1 start-up,
// 2 track, 3 convert, 4 transfer.
module adc_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        wp_en,
    input logic [31:0] reg_rdata,
    input logic [1:0]  trig_mode,
    input logic [2:0]  phase,
    input logic        core_en,
    input logic        ref_en,
    input logic        res_valid
);
    p_wp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wp_en) |=> $stable(reg_rdata));

    p_cold_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && $past(phase) == 3'd0) |-> !$past(core_en));

    p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_result_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(phase) == 3'd4 && (phase == 3'd2 || phase == 3'd0)));

    p_busy_power_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd0) |-> (core_en && ref_en));

    p_deep_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && $past(reg_rdata[5]) && !$past(reg_rdata[6])) |-> (!core_en && !ref_en));

    p_fast_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && $past(reg_rdata[5]) && $past(reg_rdata[6])) |-> (!core_en && ref_en));

    p_reserved_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd0 && $past(reg_rdata[3:1]) >= 3'd5) |-> (phase == 3'd0));

    p_mode_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd0 && $past(trig_mode) == 2'd0) |-> (phase == 3'd0));

    p_from_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd0) |-> (phase <= 3'd2));

    p_from_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd1) |-> (phase == 3'd1 || phase == 3'd2));

    p_from_track_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd2) |-> (phase == 3'd2 || phase == 3'd3));

    p_from_conv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd3) |-> (phase == 3'd3 || phase == 3'd4));

    p_from_xfer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd4) |-> (phase == 3'd4 || phase == 3'd2 || phase == 3'd0));
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .wp_en     (wp_en),
    .reg_rdata (reg_rdata),
    .trig_mode (trig_mode),
    .phase     (phase),
    .core_en   (core_en),
    .ref_en    (ref_en),
    .res_valid (res_valid)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: cases push expected (channel, cycle) items, the monitor
// pops and compares them on each result strobe.
module sim_adc_seq_ctrl;
    localparam int NCH   = 16;
    localparam int SLOTS = 8;
    localparam int NTRIG = 5;
    localparam int CONV  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        wp_en = 1'b0;
    logic [31:0] reg_rdata;
    logic [1:0]  trig_mode = 2'd0;
    logic [NTRIG-1:0] trig_in = '0;
    logic        ext_track = 1'b0;
    logic [NCH-1:0] chan_en = '0;
    logic [SLOTS*4-1:0] seq_list = '0;
    logic [3:0]  seq_len = '0;
    logic        conv_clk, core_en, ref_en, res_valid;
    logic [2:0]  phase;
    logic [3:0]  res_chan;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int q_ch[$];
    int q_t[$];
    string q_tag[$];

    adc_seq_ctrl #(.NCH(NCH), .SLOTS(SLOTS), .NTRIG(NTRIG), .CONV_CLKS(CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .wp_en(wp_en), .reg_rdata(reg_rdata), .trig_mode(trig_mode),
        .trig_in(trig_in), .ext_track(ext_track), .chan_en(chan_en),
        .seq_list(seq_list), .seq_len(seq_len), .conv_clk(conv_clk),
        .core_en(core_en), .ref_en(ref_en), .phase(phase),
        .res_valid(res_valid), .res_chan(res_chan)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected start-up periods per code, from the requirement table.
    function automatic int exp_su(input int c);
        case (c)
            0: return 0;    1: return 8;    2: return 16;   3: return 24;
            4: return 64;   5: return 80;   6: return 96;   7: return 112;
            default: return 512 + 64 * (c - 8);
        endcase
    endfunction

    // Expected tracking periods per code and extended flag.
    function automatic int exp_tr(input int c, input bit ext);
        if (!ext) return (c == 15) ? 7 : 6;
        return (c < 4) ? 6 : 4 * (c + 1) - 10;
    endfunction

    function automatic logic [31:0] mk(input bit useq, input int xfer, input int trk,
                                       input int su, input int pre, input bit fwup,
                                       input bit sleep, input int tsel);
        logic [31:0] v;
        v = 32'h4000_0000;
        v[31] = useq;
        v[29:28] = 2'(xfer);
        v[27:24] = 4'(trk);
        v[19:16] = 4'(su);
        v[15:8] = 8'(pre);
        v[6] = fwup;
        v[5] = sleep;
        v[3:1] = 3'(tsel);
        return v;
    endfunction

    task automatic wr(input logic [31:0] v, input bit wp);
        @(negedge clk);
        reg_wdata = v;
        wp_en = wp;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        wp_en = 1'b0;
    endtask

    task automatic edge_at(input int idx, input logic val, output int base);
        @(negedge clk);
        base = cyc + 1;
        trig_in[idx] = val;
    endtask

    task automatic push(input int ch, input int t, input string tag);
        q_ch.push_back(ch);
        q_t.push_back(t);
        q_tag.push_back(tag);
    endtask

    task automatic drain();
        int w = 0;
        while (q_ch.size() != 0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        if (q_ch.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R6: actual %0d results missing expected 0 missing", q_ch.size());
            q_ch.delete();
            q_t.delete();
            q_tag.delete();
        end
        repeat (200) @(negedge clk);
    endtask

    // Monitor: compare each result strobe against the scoreboard head.
    always @(negedge clk) begin
        int ech;
        int et;
        string tg;
        if (rst_n && res_valid) begin
            if (q_ch.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R12: actual result chan %0d at cycle %0d expected none", res_chan, cyc);
            end else begin
                ech = q_ch.pop_front();
                et = q_t.pop_front();
                tg = q_tag.pop_front();
                chk({tg, " channel"}, 32'(res_chan), 32'(ech));
                chk({tg, " R3 cycle"}, 32'(cyc), 32'(et));
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int b;
        int d;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset value", reg_rdata, 32'h2000_0000);
        chk("R6 reset strobe", 32'(res_valid), 32'd0);
        chk("R12 reset phase", 32'(phase), 32'd0);
        chk("R9 idle awake core", 32'(core_en), 32'd1);

        wr(32'hFFFF_FFFF, 1'b0);
        chk("R1 stored bits", reg_rdata, 32'hFF8F_FF6E);
        wr(32'h0000_0000, 1'b1);
        chk("R2 protected write", reg_rdata, 32'hFF8F_FF6E);
        wr(32'h0000_0000, 1'b0);
        chk("R2 open write", reg_rdata, 32'h0000_0000);

        // Numeric order, awake idle, retrigger during run.
        wr(mk(0, 2, 0, 0, 0, 0, 0, 0), 1'b0);
        ext_track = 1'b0;
        chan_en = 16'h8025;
        trig_mode = 2'd1;
        edge_at(0, 1'b1, b);
        n = exp_tr(0, 0) + CONV + 3;
        push(0, b + 2 * n, "R7 first");
        push(2, b + 4 * n, "R7 second");
        push(5, b + 6 * n, "R7 third");
        push(15, b + 8 * n, "R7 top index");
        repeat (3) @(negedge clk);
        trig_in[0] = 1'b0;
        repeat (30) @(negedge clk);
        edge_at(0, 1'b1, d);
        repeat (3) @(negedge clk);
        trig_in[0] = 1'b0;
        drain();

        // Deep sleep: start-up once, skipped on the second channel.
        wr(mk(0, 2, 15, 3, 1, 0, 1, 0), 1'b0);
        chan_en = 16'h0280;
        repeat (2) @(negedge clk);
        chk("R9 deep sleep core", 32'(core_en), 32'd0);
        chk("R9 deep sleep ref", 32'(ref_en), 32'd0);
        edge_at(0, 1'b1, b);
        n = exp_su(3) + exp_tr(15, 0) + CONV + 3;
        d = exp_tr(15, 0) + CONV + 3;
        push(7, b + 4 * n, "R4 R5 cold start");
        push(9, b + 4 * (n + d), "R4 warm skip");
        repeat (10) @(negedge clk);
        chk("R9 busy core", 32'(core_en), 32'd1);
        chk("R9 busy ref", 32'(ref_en), 32'd1);
        trig_in[0] = 1'b0;
        drain();

        // List order with repeats, fast wake-up, long start-up, extended track.
        wr(mk(1, 0, 4, 9, 0, 1, 1, 0), 1'b0);
        ext_track = 1'b1;
        chan_en = '0;
        seq_list = 32'h0000_C133;
        seq_len = 4'd3;
        repeat (2) @(negedge clk);
        chk("R9 fast wake core", 32'(core_en), 32'd0);
        chk("R9 fast wake ref", 32'(ref_en), 32'd1);
        edge_at(0, 1'b1, b);
        n = exp_su(9) + exp_tr(4, 1) + CONV + 1;
        d = exp_tr(4, 1) + CONV + 1;
        push(3, b + 2 * n, "R8 slot0");
        push(3, b + 2 * (n + d), "R8 slot1 repeat");
        push(1, b + 2 * (n + 2 * d), "R8 slot2");
        repeat (3) @(negedge clk);
        trig_in[0] = 1'b0;
        drain();

        // Falling-edge mode on input 4, start-up code 0 in sleep.
        wr(mk(0, 3, 2, 0, 0, 0, 1, 4), 1'b0);
        chan_en = 16'h0002;
        trig_mode = 2'd2;
        edge_at(4, 1'b1, d);
        repeat (30) @(negedge clk);
        edge_at(4, 1'b0, b);
        n = exp_su(0) + exp_tr(2, 1) + CONV + 4;
        push(1, b + 2 * n, "R11 falling R10 input4");
        drain();

        // Both-edge mode on input 2, prescaler 2, long extended track.
        wr(mk(0, 1, 15, 0, 2, 0, 0, 2), 1'b0);
        chan_en = 16'h0010;
        trig_mode = 2'd3;
        n = exp_tr(15, 1) + CONV + 2;
        edge_at(2, 1'b1, b);
        push(4, b + 6 * n, "R11 both rise R5 ext15");
        drain();
        edge_at(2, 1'b0, b);
        push(4, b + 6 * n, "R11 both fall");
        drain();

        // Reserved select code: no input reaches the sequencer.
        wr(mk(0, 2, 0, 0, 0, 0, 0, 5), 1'b0);
        chan_en = 16'hFFFF;
        trig_mode = 2'd1;
        @(negedge clk);
        trig_in = '1;
        repeat (5) @(negedge clk);
        trig_in = '0;
        repeat (100) @(negedge clk);
        chk("R10 reserved code idle", 32'(phase), 32'd0);

        // Trigger mode 0: no edge starts a sequence.
        wr(mk(0, 2, 0, 0, 0, 0, 0, 0), 1'b0);
        trig_mode = 2'd0;
        @(negedge clk);
        trig_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        trig_in[0] = 1'b0;
        repeat (100) @(negedge clk);
        chk("R11 mode off idle", 32'(phase), 32'd0);
        drain();

        summary();
        $finish;
    end
endmodule